// File: doc/BRIEF.md
# ADC Conversion Sequencer Control

This block decides which analog channel an analog-to-digital converter samples next, and when. Software controls it through one 16-bit control word. The only live bit in that word is a run flag. Setting the run flag launches a sequence. The sequencer then presents a channel index and raises a one-cycle conversion strobe. It holds that channel until an external converter returns a one-cycle completion pulse, and only then moves on.

A two-bit mode input picks one of three behaviours:
- one conversion of the first channel;
- one ascending pass over a channel window;
- an endless loop over that window.

At the end of each pass, and at each loop-back, the sequencer raises a one-cycle end-of-pass flag. In the two one-shot modes, hardware drops the run flag when the pass ends. Software can abort at any time by writing the run flag to zero. Either of two power-down requests also forces the run flag to zero and aborts. The converter itself, result storage and interrupts are outside this block.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `bus_rdata` reads 0, and `busy`, `conv_req` and `seq_end` are low.
- R2: The control word has one writable bit, bit 13 (the run flag). All other bits read 0, and writing 1 to them changes nothing. Writing 16'hDFFF while idle leaves `bus_rdata` at 0 and starts no conversion.
- R3: A write with bit 13 set, made while no standby input is high, sets the run flag from the next cycle. If the block was idle, `conv_req` pulses in the cycle after the write, with `cur_ch` equal to `first_ch`.
- R4: With `scan_mode` 2'b00 (single), only `first_ch` is converted. The `conv_done` that completes it gives a one-cycle `seq_end`, and bit 13 reads 0 from the next cycle.
- R5: With `scan_mode` 2'b01 (one pass), channels `first_ch` through `last_ch` are converted in ascending order. Each `conv_req` follows the previous `conv_done` by one cycle. The last done gives `seq_end` and clears bit 13. If `last_ch` is not above `first_ch`, only `first_ch` is converted.
- R6: With `scan_mode` 2'b10 or 2'b11 (loop), the channel wraps from the last channel back to `first_ch`. Each wrap gives a one-cycle `seq_end`, and bit 13 stays 1.
- R7: Writing 0 to bit 13 clears the run flag and `busy` in the next cycle. No further `conv_req` is issued.
- R8: While `sw_standby` or `mod_standby` is high, the run flag is cleared in the next cycle, any sequence stops, and writes of 1 to bit 13 are ignored.
- R9: `conv_done` has no effect unless the sequencer is waiting on a strobed channel. This covers `conv_done` while idle and `conv_done` in the strobe cycle itself.
- R10: If a write of 1 to bit 13 coincides with the done that ends a one-shot pass, the run flag stays 1. A new pass starts at `first_ch`, with `conv_req` in the next cycle.
- R11: `conv_req` never lasts more than one cycle. `busy` equals bit 13 of `bus_rdata` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the control word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Control word read value |
| scan_mode | input | 2 | 00 single, 01 one pass, 1x loop |
| first_ch | input | CH_W | First channel of the window |
| last_ch | input | CH_W | Last channel of the window |
| sw_standby | input | 1 | Software standby request |
| mod_standby | input | 1 | Module standby request |
| conv_done | input | 1 | One-cycle completion from the converter |
| cur_ch | output | CH_W | Channel being converted |
| conv_req | output | 1 | One-cycle conversion strobe |
| busy | output | 1 | Sequence in progress |
| seq_end | output | 1 | One-cycle end-of-pass pulse |

## Verification
The hardest case to reach is a software write of 1 landing in exactly the cycle of the final completion pulse of a one-shot pass (R10). In that cycle, hardware clearing and software setting compete for the run flag. The bench drives that collision directly in a directed case. The long random phase, with frequent writes and done pulses, reaches it again, along with standby arriving in the strobe cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  localparam logic [1:0] MODE_SINGLE = 2'b00;
  localparam logic [1:0] MODE_PASS   = 2'b01;
endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg #(
  parameter int REG_W     = 16,
  parameter int START_BIT = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             standby,
  input  logic             hw_clr,
  output logic             start_q,
  output logic             set_req,
  output logic             stop_req,
  output logic [REG_W-1:0] rdata
);
  logic start_d;

  assign set_req  = wr_en && wdata[START_BIT] && !standby;
  assign stop_req = standby || (wr_en && !wdata[START_BIT]);

  always_comb begin
    start_d = start_q;
    if (standby)     start_d = 1'b0;
    else if (wr_en)  start_d = wdata[START_BIT];
    else if (hw_clr) start_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_d;
  end

  always_comb begin
    rdata            = '0;
    rdata[START_BIT] = start_q;
  end

  // R3: an accepted write of 1 makes the run flag visible next cycle
  assert_write_sets_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[START_BIT] && !standby) |=> start_q);

  // R8: standby always clears the run flag
  assert_standby_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !start_q);
endmodule

// File: rtl/adc_ch_counter.sv
module adc_ch_counter #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            advance,
  input  logic [CH_W-1:0] first_ch,
  input  logic [CH_W-1:0] last_ch,
  output logic [CH_W-1:0] ch_q,
  output logic            at_last
);
  logic [CH_W-1:0] ch_d;
  logic            ch_en;

  assign ch_en   = load || advance;
  assign at_last = (ch_q >= last_ch);

  always_comb begin
    ch_d = ch_q;
    if (load)         ch_d = first_ch;
    else if (advance) ch_d = ch_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ch_q <= '0;
    else if (ch_en) ch_q <= ch_d;
  end

  // R5: stepping moves exactly one channel up
  assert_step_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (ch_q == CH_W'($past(ch_q) + 1'b1)));

  // R5: advancing never happens past the window end
  assert_no_step_past_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !at_last);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_q,
  input  logic       set_req,
  input  logic       stop_req,
  input  logic [1:0] mode,
  input  logic       conv_done,
  input  logic       at_last,
  output logic       load,
  output logic       advance,
  output logic       hw_clr,
  output logic       conv_req,
  output logic       busy,
  output logic       eos_q
);
  seq_state_e state_q, state_d;
  logic       eos_d;
  logic       pass_end;
  logic       looping;

  assign looping  = mode[1];
  assign pass_end = (mode == MODE_SINGLE) || at_last;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    advance = 1'b0;
    hw_clr  = 1'b0;
    eos_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if ((start_q || set_req) && !stop_req) begin
          state_d = ST_REQ;
          load    = 1'b1;
        end
      end
      ST_REQ: begin
        if (stop_req) state_d = ST_IDLE;
        else          state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (stop_req) begin
          state_d = ST_IDLE;
        end else if (conv_done) begin
          if (pass_end) begin
            eos_d = 1'b1;
            if (looping) begin
              load    = 1'b1;
              state_d = ST_REQ;
            end else begin
              hw_clr = 1'b1;
              if (set_req) begin
                load    = 1'b1;
                state_d = ST_REQ;
              end else begin
                state_d = ST_IDLE;
              end
            end
          end else begin
            advance = 1'b1;
            state_d = ST_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      eos_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      eos_q   <= eos_d;
    end
  end

  assign conv_req = (state_q == ST_REQ);
  assign busy     = (state_q != ST_IDLE);

  // R11: the strobe lasts a single cycle
  assert_req_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  // R6: the end-of-pass flag is a single-cycle pulse
  assert_eos_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eos_q |=> !eos_q);

  // R9: without done or stop, a waiting channel keeps waiting
  assert_wait_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !conv_done && !stop_req) |=> (state_q == ST_WAIT));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NUM_CH    = 8,
  parameter int REG_W     = 16,
  parameter int START_BIT = 13,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [1:0]       scan_mode,
  input  logic [CH_W-1:0]  first_ch,
  input  logic [CH_W-1:0]  last_ch,
  input  logic             sw_standby,
  input  logic             mod_standby,
  input  logic             conv_done,
  output logic [CH_W-1:0]  cur_ch,
  output logic             conv_req,
  output logic             busy,
  output logic             seq_end
);
  logic rst_n_s;
  logic standby;
  logic start_q, set_req, stop_req, hw_clr;
  logic load, advance, at_last;

  assign standby = sw_standby || mod_standby;

  adc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  adc_ctrl_reg #(.REG_W(REG_W), .START_BIT(START_BIT)) i_ctrl_reg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (bus_wr),
    .wdata    (bus_wdata),
    .standby  (standby),
    .hw_clr   (hw_clr),
    .start_q  (start_q),
    .set_req  (set_req),
    .stop_req (stop_req),
    .rdata    (bus_rdata)
  );

  adc_ch_counter #(.CH_W(CH_W)) i_ch_counter (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (load),
    .advance  (advance),
    .first_ch (first_ch),
    .last_ch  (last_ch),
    .ch_q     (cur_ch),
    .at_last  (at_last)
  );

  adc_seq_fsm i_seq_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_q   (start_q),
    .set_req   (set_req),
    .stop_req  (stop_req),
    .mode      (scan_mode),
    .conv_done (conv_done),
    .at_last   (at_last),
    .load      (load),
    .advance   (advance),
    .hw_clr    (hw_clr),
    .conv_req  (conv_req),
    .busy      (busy),
    .eos_q     (seq_end)
  );

  // R11: the run flag and the busy indication never disagree
  assert_start_tracks_busy_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    start_q == busy);

  // R7: a write of 0 leaves the block idle next cycle
  assert_stop_idles_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && !bus_wdata[START_BIT]) |=> !busy);
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 8;
  localparam int CH_W       = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0;
  logic [15:0]     bus_wdata = '0;
  logic [15:0]     bus_rdata;
  logic [1:0]      scan_mode = 2'b00;
  logic [CH_W-1:0] first_ch = '0;
  logic [CH_W-1:0] last_ch = '0;
  logic            sw_standby = 1'b0;
  logic            mod_standby = 1'b0;
  logic            conv_done = 1'b0;
  logic [CH_W-1:0] cur_ch;
  logic            conv_req, busy, seq_end;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;
  string tag = "R1";

  // expected-value model state: phase 0 idle, 1 strobe, 2 waiting
  int          m_ph = 0;
  bit          m_start = 0;
  bit          m_eos = 0;
  int          m_ch = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl #(.NUM_CH(NUM_CH)) i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .scan_mode(scan_mode), .first_ch(first_ch),
    .last_ch(last_ch), .sw_standby(sw_standby), .mod_standby(mod_standby),
    .conv_done(conv_done), .cur_ch(cur_ch), .conv_req(conv_req),
    .busy(busy), .seq_end(seq_end)
  );

  function automatic logic [15:0] exp_rdata(bit s);
    logic [15:0] v;
    v = '0;
    v[13] = s;
    return v;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // advance the model by one clock using the inputs now applied
  task automatic model_step();
    bit sb, stop, set, hwclr, endp;
    int nph, nch;
    sb    = sw_standby || mod_standby;
    stop  = sb || (bus_wr && !bus_wdata[13]);
    set   = bus_wr && bus_wdata[13] && !sb;
    hwclr = 0;
    nph   = m_ph;
    nch   = m_ch;
    m_eos = 0;
    case (m_ph)
      0: if ((m_start || set) && !stop) begin nph = 1; nch = first_ch; end
      1: nph = stop ? 0 : 2;
      default: begin
        if (stop) nph = 0;
        else if (conv_done) begin
          endp = (scan_mode == 2'b00) || (m_ch >= int'(last_ch));
          if (endp) begin
            m_eos = 1;
            if (scan_mode[1]) begin nph = 1; nch = first_ch; end
            else begin
              hwclr = 1;
              if (set) begin nph = 1; nch = first_ch; end
              else nph = 0;
            end
          end else begin
            nph = 1;
            nch = m_ch + 1;
          end
        end
      end
    endcase
    if (sb) m_start = 0;
    else if (bus_wr) m_start = bus_wdata[13];
    else if (hwclr) m_start = 0;
    m_ph = nph;
    m_ch = nch;
  endtask

  task automatic compare_all();
    check(tag, "rdata", bus_rdata, exp_rdata(m_start));
    check(tag, "busy", busy, m_ph != 0);
    check(tag, "conv_req", conv_req, m_ph == 1);
    check(tag, "seq_end", seq_end, m_eos);
    if (m_ph != 0) check(tag, "cur_ch", cur_ch, m_ch);
  endtask

  // apply inputs, clock once, compare at the falling edge
  task automatic step(bit w, logic [15:0] wd, bit ssb, bit msb, bit done);
    bus_wr = w; bus_wdata = wd; sw_standby = ssb; mod_standby = msb; conv_done = done;
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tag = "R1";
    compare_all();

    // R2: reserved bits are not writable and start nothing
    tag = "R2";
    step(1, 16'hDFFF, 0, 0, 0);
    check("R2", "rdata_after_rsvd_write", bus_rdata, 0);
    idle(2);

    // R3 + R4: single mode, converts first channel only
    tag = "R4";
    scan_mode = 2'b00; first_ch = 3'd5; last_ch = 3'd7;
    step(1, 16'hFFFF, 0, 0, 0);
    check("R3", "conv_req_after_write", conv_req, 1);
    check("R3", "cur_ch_first", cur_ch, 5);
    idle(2);
    step(0, '0, 0, 0, 1);
    check("R4", "seq_end_single", seq_end, 1);
    check("R4", "start_cleared", bus_rdata, 0);
    idle(2);

    // R5: one pass over 2..4
    tag = "R5";
    scan_mode = 2'b01; first_ch = 3'd2; last_ch = 3'd4;
    step(1, 16'h2000, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      check("R5", "pass_channel", cur_ch, 2 + k);
      step(0, '0, 0, 0, 0);
      step(0, '0, 0, 0, 1);
    end
    check("R5", "pass_end_flag", seq_end, 1);
    check("R5", "pass_idle", busy, 0);
    idle(2);

    // R9: done during the strobe cycle and while idle are ignored
    tag = "R9";
    step(0, '0, 0, 0, 1);
    step(1, 16'h2000, 0, 0, 1);
    step(0, '0, 0, 0, 1);
    check("R9", "done_in_strobe_ignored", cur_ch, 2);
    idle(1);

    // R7: software stop
    tag = "R7";
    step(1, 16'h0000, 0, 0, 0);
    check("R7", "busy_after_stop", busy, 0);
    idle(3);

    // R6: loop mode wraps and keeps the flag
    tag = "R6";
    scan_mode = 2'b10; first_ch = 3'd6; last_ch = 3'd7;
    step(1, 16'h2000, 0, 0, 0);
    for (int k = 0; k < 6; k++) begin step(0, '0, 0, 0, 0); step(0, '0, 0, 0, 1); end
    check("R6", "flag_stays_in_loop", bus_rdata, 16'h2000);

    // R8: standby stops, write of 1 ignored during standby
    tag = "R8";
    step(0, '0, 0, 1, 0);
    check("R8", "busy_after_standby", busy, 0);
    step(1, 16'h2000, 1, 0, 0);
    check("R8", "write_ignored_in_standby", bus_rdata, 0);
    idle(2);

    // R10: write of 1 collides with the final done
    tag = "R10";
    scan_mode = 2'b01; first_ch = 3'd1; last_ch = 3'd1;
    step(1, 16'h2000, 0, 0, 0);
    step(0, '0, 0, 0, 0);
    step(1, 16'h2000, 0, 0, 1);
    check("R10", "restart_strobe", conv_req, 1);
    check("R10", "flag_kept", bus_rdata, 16'h2000);
    idle(3);
    step(1, 16'h0000, 0, 0, 0);

    // random phase covering R3 R5 R6 R9 R11 and collisions
    tag = "R11";
    void'($urandom(32'd7319));
    for (int i = 0; i < 4000; i++) begin
      bit w, ssb, msb, dn;
      logic [15:0] wd;
      if (i % 250 == 0) begin
        scan_mode = 2'($urandom_range(0, 3));
        first_ch  = CH_W'($urandom_range(0, NUM_CH - 1));
        last_ch   = CH_W'($urandom_range(0, NUM_CH - 1));
      end
      w   = ($urandom_range(0, 19) == 0);
      wd  = 16'($urandom);
      if ($urandom_range(0, 2) != 0) wd[13] = 1'b1;
      ssb = ($urandom_range(0, 99) == 0);
      msb = ($urandom_range(0, 99) == 0);
      dn  = ($urandom_range(0, 2) == 0);
      step(w, wd, ssb, msb, dn);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule